// File: doc/BRIEF.md
# Next Program Counter Unit with Delay Slot

This block decides which 32-bit address the fetch stage of a RISC core requests next. For every instruction it consumes, it receives that instruction's address, a decoded control class, the 16-bit branch displacement, the 26-bit jump field and two register operands. It returns the next fetch address, a flag for a taken control transfer, and the return address and write strobe for the link register (general register 31).

The core has one branch delay slot, so a transfer never takes effect at once. When a transfer is taken, the unit first returns the sequential address so that the delay-slot instruction is fetched. It keeps the computed destination in a register and returns it when the delay-slot instruction is consumed. A two-state machine tracks this. RUN is the normal state, and the transition RUN->SLOT happens on a taken transfer. SLOT is the state in which a destination is pending, and the transition SLOT->RUN happens on the next advance. While the `adv` strobe is low the state and the pending destination are held.

Top module: `nxpc_unit`

## Requirements
- R1: After reset the unit is in RUN with no pending destination. On an advance of a sequential instruction (control class 0) `nxt_pc` equals `cur_pc`+4 and `taken` is low.
- R2: Control class 1 (branch-if-equal) is taken exactly when `op_a` equals `op_b`. When it is not taken, `nxt_pc` is `cur_pc`+4 and the following advance is sequential.
- R3: Control class 2 (branch-if-different) is taken exactly when `op_a` differs from `op_b`.
- R4: On a taken transfer, `nxt_pc` is `cur_pc`+4 (the delay slot) and `taken` is high. For a branch the destination is `cur_pc`+4 plus the sign-extended `br_off` shifted left by 2. That destination appears on `nxt_pc` during the next advance, and the unit then returns to RUN.
- R5: Control class 3 (jump) is always taken. Its destination is bits 31:28 of `cur_pc`+4 followed by `j_tgt`, followed by two zero bits.
- R6: Control class 4 (jump-and-link) jumps like class 3 and in the same cycle raises `link_we` with `link_val` = `cur_pc`+8, the address after the delay slot.
- R7: Control class 5 (register jump) is always taken, and its destination is `op_a`.
- R8: A register jump whose `op_a` has a nonzero value in bits 1:0 raises `misalign` in its advance cycle. The jump still proceeds. `misalign` is low for an aligned register jump and for all other classes.
- R9: The control class of the delay-slot instruction has no effect. While a destination is pending, `taken`, `link_we` and `misalign` stay low and `nxt_pc` is the pending destination.
- R10: While `adv` is low, `taken`, `link_we` and `misalign` are low, and the state and the pending destination are held for the next advance.
- R11: Control classes 6 and 7 behave as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv | input | 1 | The instruction on the inputs is consumed this cycle |
| cur_pc | input | 32 | Address of the consumed instruction |
| ctl | input | 3 | Control class: 0 seq, 1 branch-equal, 2 branch-different, 3 jump, 4 jump-and-link, 5 register jump |
| br_off | input | 16 | Signed branch displacement in words |
| j_tgt | input | 26 | Jump word-address field |
| op_a | input | 32 | First register operand, also the register-jump destination |
| op_b | input | 32 | Second register operand for comparison |
| nxt_pc | output | 32 | Address to fetch next |
| taken | output | 1 | A control transfer is taken by this instruction |
| link_val | output | 32 | Return address for register 31 |
| link_we | output | 1 | Write `link_val` into register 31 |
| misalign | output | 1 | Register-jump destination is not word-aligned |

## Verification
All outputs are combinational on the inputs and the state, so the results for an advance are due in the same cycle as that advance. The single exception is a taken destination, which is due in the next advancing cycle, however many idle cycles come in between. The driver sets inputs on the falling edge and queues the expected values. The monitor samples one nanosecond later, before the next rising edge. Destinations are checked on the advance that follows a transfer, and the bench's own delay-slot model tracks which advance that is.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
    localparam int CTL_W = 3;

    typedef enum logic [CTL_W-1:0] {
        CTL_SEQ  = 3'd0,
        CTL_BEQ  = 3'd1,
        CTL_BNE  = 3'd2,
        CTL_JMP  = 3'd3,
        CTL_JAL  = 3'd4,
        CTL_JREG = 3'd5
    } ctl_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } fsm_e;
endpackage

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [CTL_W-1:0] ctl,
    input  logic [OFF_W-1:0] br_off,
    input  logic [TGT_W-1:0] j_tgt,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    output logic [XLEN-1:0]  pc4,
    output logic [XLEN-1:0]  dest,
    output logic             want,
    output logic             is_link,
    output logic             bad_align
);
    localparam int SEXT_W = XLEN - OFF_W - 2;
    localparam int HI_W   = XLEN - TGT_W - 2;

    ctl_e             kind;
    logic [XLEN-1:0]  br_dest;
    logic [XLEN-1:0]  jp_dest;

    assign kind    = ctl_e'(ctl);
    assign pc4     = cur_pc + {{(XLEN-3){1'b0}}, 3'd4};
    assign br_dest = pc4 + {{SEXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
    assign jp_dest = {pc4[XLEN-1 -: HI_W], j_tgt, 2'b00};

    always_comb begin
        want      = 1'b0;
        dest      = pc4;
        is_link   = 1'b0;
        bad_align = 1'b0;
        unique case (kind)
            CTL_BEQ: begin
                want = (op_a == op_b);
                dest = br_dest;
            end
            CTL_BNE: begin
                want = (op_a != op_b);
                dest = br_dest;
            end
            CTL_JMP: begin
                want = 1'b1;
                dest = jp_dest;
            end
            CTL_JAL: begin
                want    = 1'b1;
                dest    = jp_dest;
                is_link = 1'b1;
            end
            CTL_JREG: begin
                want      = 1'b1;
                dest      = op_a;
                bad_align = (op_a[1:0] != 2'b00);
            end
            default: begin
                want = 1'b0;
                dest = pc4;
            end
        endcase
    end
endmodule

// File: rtl/nxpc_fsm.sv
module nxpc_fsm
    import nxpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            want,
    input  logic [XLEN-1:0] dest,
    output logic            in_slot,
    output logic            grant,
    output logic [XLEN-1:0] pend
);
    fsm_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (adv && want) state_nx = ST_SLOT;
            ST_SLOT: if (adv)         state_nx = ST_RUN;
            default:                  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            pend  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && adv && want) pend <= dest;
        end
    end

    always_comb begin
        in_slot = 1'b0;
        grant   = 1'b0;
        unique case (state)
            ST_RUN:  grant   = adv;
            ST_SLOT: in_slot = 1'b1;
            default: grant   = 1'b0;
        endcase
    end
endmodule

// File: rtl/nxpc_link.sv
module nxpc_link #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic            is_link,
    input  logic            grant,
    output logic [XLEN-1:0] link_val,
    output logic            link_we
);
    assign link_val = cur_pc + {{(XLEN-4){1'b0}}, 4'd8};
    assign link_we  = grant && is_link;
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [CTL_W-1:0] ctl,
    input  logic [OFF_W-1:0] br_off,
    input  logic [TGT_W-1:0] j_tgt,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    output logic [XLEN-1:0]  nxt_pc,
    output logic             taken,
    output logic [XLEN-1:0]  link_val,
    output logic             link_we,
    output logic             misalign
);
    logic [XLEN-1:0] pc4_w, dest_w, pend_w;
    logic            want_w, is_link_w, bad_w, in_slot_w, grant_w;

    nxpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
        .cur_pc(cur_pc), .ctl(ctl), .br_off(br_off), .j_tgt(j_tgt),
        .op_a(op_a), .op_b(op_b), .pc4(pc4_w), .dest(dest_w),
        .want(want_w), .is_link(is_link_w), .bad_align(bad_w)
    );

    nxpc_fsm #(.XLEN(XLEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .adv(adv), .want(want_w), .dest(dest_w),
        .in_slot(in_slot_w), .grant(grant_w), .pend(pend_w)
    );

    nxpc_link #(.XLEN(XLEN)) u_link (
        .cur_pc(cur_pc), .is_link(is_link_w), .grant(grant_w),
        .link_val(link_val), .link_we(link_we)
    );

    assign nxt_pc   = in_slot_w ? pend_w : pc4_w;
    assign taken    = grant_w && want_w;
    assign misalign = grant_w && bad_w;
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adv,
    input logic [2:0]      ctl,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] nxt_pc,
    input logic            taken,
    input logic            link_we,
    input logic            misalign,
    input logic            in_slot,
    input logic [XLEN-1:0] dest
);
    p_seq_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !in_slot && !taken) |-> nxt_pc == cur_pc + 32'd4);

    p_enter_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && taken) |=> (in_slot && nxt_pc == $past(dest)));

    p_leave_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && in_slot) |=> !in_slot);

    p_link_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (taken && ctl == 3'd4));

    p_misalign_jr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (taken && ctl == 3'd5));

    p_slot_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |-> (!taken && !link_we && !misalign));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(in_slot) && (!in_slot || $stable(nxt_pc))));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |-> (!taken && !link_we && !misalign));
endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ctl(ctl), .cur_pc(cur_pc),
    .nxt_pc(nxt_pc), .taken(taken), .link_we(link_we), .misalign(misalign),
    .in_slot(in_slot_w), .dest(dest_w)
);

// File: tb/tb_nxpc_unit.sv
`timescale 1ns/1ps
module tb_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [2:0]  ctl = '0;
    logic [15:0] br_off = '0;
    logic [25:0] j_tgt = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] nxt_pc, link_val;
    logic        taken, link_we, misalign;

    always #2 clk = ~clk;

    nxpc_unit dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .cur_pc(cur_pc), .ctl(ctl),
        .br_off(br_off), .j_tgt(j_tgt), .op_a(op_a), .op_b(op_b),
        .nxt_pc(nxt_pc), .taken(taken), .link_val(link_val),
        .link_we(link_we), .misalign(misalign)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] q_pc[$];
    logic [31:0] q_lv[$];
    logic [3:0]  q_flags[$];
    bit          q_chkpc[$];
    string       q_tag[$];

    logic        m_pend_v = 1'b0;
    logic [31:0] m_pend = '0;

    task automatic issue(input bit a, input logic [31:0] pc, input logic [2:0] c,
                         input logic [15:0] off, input logic [25:0] jt,
                         input logic [31:0] ra, input logic [31:0] rb, input string tag);
        logic [31:0] pc4, dst, e_nxt, e_lv;
        logic        go, e_tk, e_lwe, e_mis;
        @(negedge clk);
        adv = a; cur_pc = pc; ctl = c; br_off = off; j_tgt = jt; op_a = ra; op_b = rb;
        pc4 = pc + 32'd4;
        go = 1'b0; dst = pc4; e_lwe = 1'b0; e_mis = 1'b0;
        case (c)
            3'd1: begin go = (ra == rb); dst = pc4 + {{14{off[15]}}, off, 2'b00}; end
            3'd2: begin go = (ra != rb); dst = pc4 + {{14{off[15]}}, off, 2'b00}; end
            3'd3: begin go = 1'b1; dst = {pc4[31:28], jt, 2'b00}; end
            3'd4: begin go = 1'b1; dst = {pc4[31:28], jt, 2'b00}; e_lwe = 1'b1; end
            3'd5: begin go = 1'b1; dst = ra; e_mis = (ra[1:0] != 2'b00); end
            default: go = 1'b0;
        endcase
        e_lv = pc + 32'd8;
        if (m_pend_v) begin
            e_nxt = m_pend; e_tk = 1'b0; e_lwe = 1'b0; e_mis = 1'b0;
            if (a) m_pend_v = 1'b0;
        end else if (!a) begin
            e_nxt = pc4; e_tk = 1'b0; e_lwe = 1'b0; e_mis = 1'b0;
        end else begin
            e_nxt = pc4; e_tk = go;
            if (!go) begin e_lwe = 1'b0; e_mis = 1'b0; end
            if (go) begin m_pend_v = 1'b1; m_pend = dst; end
        end
        q_pc.push_back(e_nxt);
        q_lv.push_back(e_lv);
        q_flags.push_back({e_tk, e_lwe, e_mis, 1'b0});
        q_chkpc.push_back(a || m_pend_v);
        q_tag.push_back(tag);
    endtask

    initial begin : monitor
        logic [31:0] e_pc, e_lv;
        logic [3:0]  e_f;
        bit          cp;
        string       tg;
        forever begin
            @(negedge clk);
            #1;
            if (q_pc.size() != 0) begin
                e_pc = q_pc.pop_front(); e_lv = q_lv.pop_front();
                e_f = q_flags.pop_front(); cp = q_chkpc.pop_front(); tg = q_tag.pop_front();
                checks++;
                if ((cp && nxt_pc !== e_pc) || taken !== e_f[3] || link_we !== e_f[2] ||
                    misalign !== e_f[1] || (e_f[2] && link_val !== e_lv)) begin
                    errors++;
                    $display("FAIL %s: got nxt=%h tk=%b lwe=%b lv=%h mis=%b, exp nxt=%h tk=%b lwe=%b lv=%h mis=%b",
                             tg, nxt_pc, taken, link_we, link_val, misalign,
                             e_pc, e_f[3], e_f[2], e_lv, e_f[1]);
                end
            end
        end
    end

    initial begin : watchdog
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running, exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, idle cycle is quiet
        issue(0, 32'h100, 3'd0, 16'h0, 26'h0, 0, 0, "R1");
        issue(1, 32'h100, 3'd0, 16'h0, 26'h0, 0, 0, "R1");
        // R11: unused classes are sequential
        issue(1, 32'h104, 3'd6, 16'h7, 26'h5, 1, 1, "R11");
        issue(1, 32'h108, 3'd7, 16'h7, 26'h5, 1, 2, "R11");
        // R2 / R4: equal branch taken, forward offset
        issue(1, 32'h10C, 3'd1, 16'h0010, 26'h0, 5, 5, "R2");
        issue(1, 32'h110, 3'd0, 16'h0, 26'h0, 0, 0, "R4");
        // R2: equal branch not taken
        issue(1, 32'h150, 3'd1, 16'h0010, 26'h0, 5, 6, "R2");
        issue(1, 32'h154, 3'd0, 16'h0, 26'h0, 0, 0, "R2");
        // R3 / R4: different branch taken, backward offset
        issue(1, 32'h158, 3'd2, 16'hFFFC, 26'h0, 1, 2, "R3");
        issue(1, 32'h15C, 3'd0, 16'h0, 26'h0, 0, 0, "R4");
        issue(1, 32'h14C, 3'd2, 16'hFFFC, 26'h0, 9, 9, "R3");
        // R5 / R9: jump with a link class in the delay slot
        issue(1, 32'hF000_0100, 3'd3, 16'h0, 26'h0ABCDE, 0, 0, "R5");
        issue(1, 32'hF000_0104, 3'd4, 16'h0, 26'h000001, 0, 0, "R9");
        issue(1, 32'hF02A_F378, 3'd0, 16'h0, 26'h0, 0, 0, "R5");
        // R6: jump-and-link writes PC+8
        issue(1, 32'h0000_0200, 3'd4, 16'h0, 26'h123456, 0, 0, "R6");
        issue(1, 32'h0000_0204, 3'd5, 16'h0, 26'h0, 32'h3, 0, "R9");
        // R7: aligned register jump
        issue(1, 32'h0048_D158, 3'd5, 16'h0, 26'h0, 32'h3000, 0, "R7");
        issue(1, 32'h0048_D15C, 3'd0, 16'h0, 26'h0, 0, 0, "R7");
        // R8: misaligned register jump still proceeds
        issue(1, 32'h3000, 3'd5, 16'h0, 26'h0, 32'h4002, 0, "R8");
        issue(1, 32'h3004, 3'd0, 16'h0, 26'h0, 0, 0, "R8");
        // R10: idle cycles between transfer and delay slot
        issue(1, 32'h4002, 3'd1, 16'h0020, 26'h0, 7, 7, "R10");
        issue(0, 32'h9990, 3'd3, 16'h0, 26'h1, 0, 0, "R10");
        issue(0, 32'h9994, 3'd5, 16'h0, 26'h0, 32'h1, 0, "R10");
        issue(1, 32'h4006, 3'd0, 16'h0, 26'h0, 0, 0, "R10");
        // R1: sequential wrap at top of address space
        issue(1, 32'hFFFF_FFFC, 3'd0, 16'h0, 26'h0, 0, 0, "R1");
        issue(0, 32'h0, 3'd0, 16'h0, 26'h0, 0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule